// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master driven from a small 32-bit register port. Software programs a control word (enable, master mode, clock polarity and phase, bit order, manual select and a transmit-hold gate), queues outgoing words in a transmit FIFO, reads back captured words from a receive FIFO and drives the slave-select lines through a dedicated register. Each word that is shifted out on MOSI brings one word in from MISO, and that word is pushed into the receive FIFO.

The word width (8, 16 or 32 bits), the FIFO depth (a power of two) and the serial clock rate are fixed when the block is built. A typical sequence sets the transmit-hold bit, loads several words, then clears the hold bit to release them as a continuous burst. When the last queued word has gone out, the serial clock parks at the level chosen by the polarity bit.

Top module: `spi_host_ctrl`

## Requirements
- R1: Register word addresses are 0 control, 1 status, 2 transmit data, 3 receive data, 4 select. Status bits are bit0 receive FIFO empty, bit1 receive FIFO full, bit2 transmit FIFO empty, bit3 transmit FIFO full and bit4 mode fault, which always reads 0. After reset, status reads 0x05, control reads 0, every select line is high and SCK is low.
- R2: While control bit 8 (transmit hold) is set, no word leaves the transmit FIFO and SCK does not toggle. Queued words are sent once the bit clears, provided bit 1 (enable) and bit 2 (master) are both set.
- R3: With CPOL and CPHA both 0 and MSB-first order, each queued word appears on MOSI most significant bit first, and the word clocked in from MISO is pushed into the receive FIFO. Reading address 3 pops one word.
- R4: Control bit 3 (CPOL) sets the idle SCK level and bit 4 (CPHA) chooses whether data is sampled on the leading edge (0) or on the trailing edge (1). All four combinations exchange words correctly, and SCK returns to the CPOL level after the last word.
- R5: With control bit 9 set, words leave and arrive least significant bit first. Both the transmitted and the received word keep their register bit weights.
- R6: Select lines follow the select register while control bit 7 (manual select) is set, and all lines are high while it is clear. Writing the complement of (1 << n) drives only line n low.
- R7: A write to the transmit data register while the transmit FIFO holds DEPTH words is dropped, and status bit 3 reads 1.
- R8: A received word is dropped when the receive FIFO is full, and the words already held are kept.
- R9: Writing control with bit 5 set empties the transmit FIFO, and writing it with bit 6 set empties the receive FIFO. Both bits read back as 0.
- R10: Clearing enable during a word lets that word finish, starts no further word and leaves SCK at its idle level. The rest of the queue stays in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 3) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSEL | Active-low slave selects |

## Verification
If the transmit pointer or count is wrong, the result shows up at the ports within one word time: a serial word goes missing or is repeated, or status bit 2 reads the wrong value on the next status read. If the shift engine loses its edge count, the bench's serial slave collects a word in the wrong bit order or with the wrong number of bits, and SCK fails to settle at the CPOL level once the queue drains. If the receive FIFO is corrupted by an overflow, it shows only when the held words are popped, so those checks drain the FIFO in full.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_TXD  = 3'd2,
    RA_RXD  = 3'd3,
    RA_SEL  = 3'd4
  } reg_addr_e;

  // control bit positions (software decodes these)
  localparam int CB_EN   = 1;
  localparam int CB_MAST = 2;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 4;
  localparam int CB_TXR  = 5;
  localparam int CB_RXR  = 6;
  localparam int CB_MAN  = 7;
  localparam int CB_HOLD = 8;
  localparam int CB_LSB  = 9;
  localparam int CTRL_W  = 10;
  // stored bits: reset strobes and bit 0 are not kept
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 10'h39E;

  // reverse the low w bits of v
  function automatic logic [31:0] flip_bits(logic [31:0] v, int unsigned w);
    logic [31:0] r;
    r = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < w) r[i] = v[w-1-i];
    end
    return r;
  endfunction

  // which SCK edge index captures MISO
  function automatic logic is_sample_edge(logic cpha, logic idx_lsb);
    return cpha ? idx_lsb : ~idx_lsb;
  endfunction

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
  parameter int W        = 8,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  import spi_host_pkg::*;

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EW = $clog2(2 * W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);
  localparam logic [DW-1:0] DIV_TOP   = DW'(HALF_DIV - 1);

  logic [DW-1:0] div;
  logic [EW-1:0] idx;
  logic          ph, lat_cpol, lat_cpha, lat_lsb;
  logic [W-1:0]  sh, rxs;
  logic          tick, samp;

  assign tick    = (div == DIV_TOP);
  assign samp    = is_sample_edge(lat_cpha, idx[0]);
  assign sclk    = busy ? (lat_cpol ^ ph) : cpol;
  assign mosi    = sh[W-1];
  assign rx_word = lat_lsb ? W'(flip_bits(32'(rxs), W)) : rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      div      <= '0;
      idx      <= '0;
      ph       <= 1'b0;
      sh       <= '0;
      rxs      <= '0;
      lat_cpol <= 1'b0;
      lat_cpha <= 1'b0;
      lat_lsb  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        div      <= '0;
        idx      <= '0;
        ph       <= 1'b0;
        sh       <= lsb ? W'(flip_bits(32'(word), W)) : word;
        lat_cpol <= cpol;
        lat_cpha <= cpha;
        lat_lsb  <= lsb;
      end else if (busy) begin
        if (tick) begin
          div <= '0;
          ph  <= ~ph;
          idx <= idx + 1'b1;
          if (samp)             rxs <= {rxs[W-2:0], miso};
          else if (idx != '0)   sh  <= {sh[W-2:0], 1'b0};
          if (idx == LAST_EDGE) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl #(
  parameter int WORD_W   = 8,
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  parameter int NSEL     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [NSEL-1:0] spi_ss_n
);
  import spi_host_pkg::*;

  localparam int CW = $clog2(DEPTH) + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NSEL-1:0]   sel_q;

  // named internal events
  logic          ctrl_wr, tx_wr, rx_pop, tx_clr, rx_clr, eng_start;
  logic          eng_busy, eng_done;
  logic [WORD_W-1:0] tx_head, rx_head, eng_rx;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_count, rx_count;

  assign ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
  assign tx_wr     = bus_wr && (bus_addr == RA_TXD);
  assign rx_pop    = bus_rd && (bus_addr == RA_RXD);
  assign tx_clr    = ctrl_wr && bus_wdata[CB_TXR];
  assign rx_clr    = ctrl_wr && bus_wdata[CB_RXR];
  assign eng_start = ctrl_q[CB_EN] && ctrl_q[CB_MAST] && !ctrl_q[CB_HOLD]
                     && !tx_empty && !eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '1;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (bus_wr && (bus_addr == RA_SEL)) sel_q <= bus_wdata[NSEL-1:0];
    end
  end

  spi_host_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_wr), .din(bus_wdata[WORD_W-1:0]),
    .pop(eng_start), .dout(tx_head),
    .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spi_host_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_done), .din(eng_rx),
    .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  spi_host_engine #(.W(WORD_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .word(tx_head),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]), .lsb(ctrl_q[CB_LSB]),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx)
  );

  assign spi_ss_n = ctrl_q[CB_MAN] ? sel_q : '1;

  always_comb begin
    case (bus_addr)
      RA_CTRL: bus_rdata = 32'(ctrl_q);
      RA_STAT: bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      RA_RXD:  bus_rdata = 32'(rx_head);
      RA_SEL:  bus_rdata = 32'(sel_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     eng_busy,
  input logic                     eng_done,
  input logic                     hold,
  input logic                     sclk,
  input logic                     cpol,
  input logic                     tx_clr,
  input logic                     tx_empty,
  input logic                     tx_full,
  input logic                     tx_wr,
  input logic                     tx_pop,
  input logic [$clog2(DEPTH):0]   rx_count
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R2: a word only starts after a cycle with the hold bit clear
  a_r2_no_start_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> !$past(hold));

  // R4: the clock is parked at its idle level when a word completes
  a_r4_idle_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (sclk == cpol));

  // R7: a write into a full transmit FIFO leaves it full
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && !tx_pop && !tx_clr) |=> tx_full);

  // R8: the receive FIFO never holds more than DEPTH words
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  // R9: a transmit FIFO reset empties it on the next cycle
  a_r9_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> tx_empty);
endmodule

bind spi_host_ctrl spi_host_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_done(eng_done),
  .hold(ctrl_q[8]), .sclk(spi_sclk), .cpol(ctrl_q[3]),
  .tx_clr(tx_clr), .tx_empty(tx_empty), .tx_full(tx_full),
  .tx_wr(tx_wr), .tx_pop(eng_start), .rx_count(rx_count)
);

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
  localparam int W = 8, DEPTH = 16, HD = 2, NSEL = 4;
  localparam int WORD_CYC = 2 * W * HD + 2;
  localparam logic [31:0] EN = 32'h2, MS = 32'h4, CPOL = 32'h8, CPHA = 32'h10,
    TXR = 32'h20, RXR = 32'h40, MAN = 32'h80, HOLD = 32'h100, LSB = 32'h200;
  localparam logic [31:0] BASE = EN | MS | MAN;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [NSEL-1:0] spi_ss_n;
  int total = 0, bad = 0;

  spi_host_ctrl #(.WORD_W(W), .DEPTH(DEPTH), .HALF_DIV(HD), .NSEL(NSEL)) i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n));

  always #2.5 clk = ~clk;

  // ---------------- bench serial slave ----------------
  logic b_cpol = 0, b_cpha = 0, armed = 0;
  logic [W-1:0] s_in = 0, s_out = 0;
  logic [W-1:0] s_got [64];
  int s_bits = 0, s_words = 0;

  function automatic logic [W-1:0] pat(int k);
    return W'(32'h3C + 32'(k) * 32'd29) ^ W'(32'h5A);
  endfunction
  function automatic logic [W-1:0] rev(logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  assign spi_miso = s_out[W-1];

  always @(spi_sclk) begin
    if (armed && ((!b_cpha && spi_sclk !== b_cpol) || (b_cpha && spi_sclk === b_cpol))) begin
      s_in = {s_in[W-2:0], spi_mosi};
      s_out = s_out << 1;
      s_bits++;
      if (s_bits == W) begin
        s_got[s_words] = s_in;
        s_words++;
        s_bits = 0;
        s_out = pat(s_words);
      end
    end
  end

  task automatic arm(input logic cp, input logic ch);
    b_cpol = cp; b_cpha = ch;
    s_words = 0; s_bits = 0; s_out = pat(0); armed = 1;
  endtask

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #0.5 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); check("R1 status after reset", v, 32'h5);
    rd(3'd0, v); check("R1 control after reset", v, 32'h0);
    check("R1 selects after reset", 32'(spi_ss_n), 32'hF);
    check("R1 sclk after reset", 32'(spi_sclk), 32'h0);
  endtask

  task automatic t_select;
    wr(3'd0, BASE | HOLD);
    wr(3'd4, ~(32'h1 << 2));
    idle(1); check("R6 select line 2", 32'(spi_ss_n), 32'hB);
    wr(3'd0, EN | MS | HOLD);
    idle(1); check("R6 manual off deselects", 32'(spi_ss_n), 32'hF);
    wr(3'd4, 32'hF);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(3'd0, BASE | HOLD | TXR | RXR);
    arm(0, 0);
    for (int k = 0; k < 3; k++) wr(3'd2, 32'(8'hC1 + k * 8'h13));
    idle(4 * WORD_CYC);
    rd(3'd1, v); check("R2 held queue status", v, 32'h1);
    check("R2 nothing shifted while held", 32'(s_words), 32'd0);
    rd(3'd0, v); check("R9 reset bits read 0", v, BASE | HOLD);
    wr(3'd0, BASE);
    idle(3 * WORD_CYC + 20);
    check("R2 released words sent", 32'(s_words), 32'd3);
    for (int k = 0; k < 3; k++) begin
      check("R3 mosi word", 32'(s_got[k]), 32'(W'(8'hC1 + k * 8'h13)));
      rd(3'd3, v); check("R3 miso word", v, 32'(pat(k)));
    end
  endtask

  task automatic t_modes;
    logic [31:0] v, m;
    logic [W-1:0] tw;
    for (int mode = 0; mode < 8; mode++) begin
      m = (mode[0] ? CPOL : 0) | (mode[1] ? CPHA : 0) | (mode[2] ? LSB : 0);
      wr(3'd0, BASE | HOLD | TXR | RXR | m);
      idle(2);
      arm(mode[0], mode[1]);
      for (int k = 0; k < 2; k++) wr(3'd2, 32'(W'(8'h96 ^ (mode * 8'h21 + k))));
      wr(3'd0, BASE | m);
      idle(2 * WORD_CYC + 20);
      check(mode[2] ? "R5 word count" : "R4 word count", 32'(s_words), 32'd2);
      for (int k = 0; k < 2; k++) begin
        tw = W'(8'h96 ^ (mode * 8'h21 + k));
        check(mode[2] ? "R5 wire order out" : "R4 wire data out",
              32'(s_got[k]), 32'(mode[2] ? rev(tw) : tw));
        rd(3'd3, v);
        check(mode[2] ? "R5 captured word" : "R4 captured word",
              v, 32'(mode[2] ? rev(pat(k)) : pat(k)));
      end
      check("R4 sclk idle level", 32'(spi_sclk), 32'(mode[0]));
    end
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(3'd0, BASE | HOLD | TXR | RXR);
    idle(2); arm(0, 0);
    for (int k = 0; k < DEPTH + 2; k++) wr(3'd2, 32'(8'h40 + k));
    rd(3'd1, v); check("R7 transmit full flag", v, 32'h9);
    wr(3'd0, BASE);
    idle(DEPTH * WORD_CYC + 20);
    check("R7 only DEPTH words sent", 32'(s_words), 32'(DEPTH));
    check("R7 last accepted word", 32'(s_got[DEPTH-1]), 32'(8'h40 + DEPTH - 1));
    rd(3'd1, v); check("R8 receive full flag", v, 32'h6);
    wr(3'd2, 32'hEE);
    idle(WORD_CYC + 20);
    check("R8 extra word sent", 32'(s_words), 32'(DEPTH + 1));
    for (int k = 0; k < DEPTH; k++) begin
      rd(3'd3, v); check("R8 held word kept", v, 32'(pat(k)));
    end
    rd(3'd1, v); check("R8 extra word dropped", v, 32'h5);
  endtask

  task automatic t_fifo_reset;
    logic [31:0] v;
    wr(3'd0, BASE | HOLD | TXR | RXR);
    idle(2); arm(0, 0);
    for (int k = 0; k < 3; k++) wr(3'd2, 32'(k + 1));
    rd(3'd1, v); check("R9 queue loaded", v, 32'h1);
    wr(3'd0, BASE | HOLD | TXR);
    rd(3'd1, v); check("R9 transmit reset empties", v, 32'h5);
    for (int k = 0; k < 2; k++) wr(3'd2, 32'(k + 7));
    wr(3'd0, BASE);
    idle(2 * WORD_CYC + 20);
    rd(3'd1, v); check("R9 receive holds words", v, 32'h4);
    wr(3'd0, BASE | RXR);
    rd(3'd1, v); check("R9 receive reset empties", v, 32'h5);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(3'd0, BASE | HOLD | TXR | RXR);
    idle(2); arm(0, 0);
    for (int k = 0; k < 3; k++) wr(3'd2, 32'(8'h70 + k));
    wr(3'd0, BASE);
    idle(5);
    wr(3'd0, MS | MAN);
    idle(4 * WORD_CYC);
    check("R10 current word finished", 32'(s_words), 32'd1);
    check("R10 sclk idle", 32'(spi_sclk), 32'd0);
    rd(3'd1, v); check("R10 rest still queued", v, 32'h0);
    rd(3'd3, v); check("R10 finished word captured", v, 32'(pat(0)));
    check("R10 finished word sent", 32'(s_got[0]), 32'h70);
    wr(3'd0, BASE | HOLD | TXR | RXR);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset;
    t_select;
    t_hold;
    t_modes;
    t_full;
    t_fifo_reset;
    t_enable;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule